// File: doc/BRIEF.md
# CPU Power State Sequencer

This block decides whether the processor core is executing, paused with its oscillator still running, or fully asleep with the oscillator stopped. It takes one-cycle strobes from the instruction decoder that request a pause (HALT) or a deep stop (SLEEP). It also takes a pending-interrupt summary from the interrupt controller, the dedicated K10 input interrupt request, a watchdog expiry pulse and the present oscillator configuration. From these it drives the core clock gate, the main oscillator enable, a restart request and a running indication.

The two low-power states wake differently. A pause ends on any pending interrupt. If no interrupt arrives, a watchdog expiry ends it with a one-cycle restart request. A deep stop turns the oscillator off and ends only on the K10 request. The core then stays gated through a settling window of `STAB_CYCLES` cycles, counted down while the oscillator runs again. A deep stop is legal only while the core runs from the slow clock and the fast oscillator is off. Any other request is refused, and the refusal is latched in an error flag.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset (`rst_n` low) the state is RUN and `cpu_clk_en`=1, `osc_en`=1, `cpu_running`=1, `reset_req`=0, `sleep_err`=0.
- R2: The state code on `state_o` is RUN=2'b00, HALT=2'b01, SLEEP=2'b10, WAKE_WAIT=2'b11. `cpu_clk_en` and `cpu_running` are 1 only in RUN, and `osc_en` is 0 only in SLEEP.
- R3: In RUN, `halt_req` with `sleep_req` low moves the state to HALT at the next clock edge.
- R4: In HALT, `irq_pending`=1 returns the state to RUN at the next edge with `reset_req` staying 0. This holds even when `wdt_timeout` is high in the same cycle.
- R5: In HALT, `wdt_timeout`=1 with `irq_pending`=0 returns the state to RUN at the next edge, and `reset_req` is 1 for exactly that one following cycle. With neither input high, the state stays HALT.
- R6: In RUN, `sleep_req` with `clk_sel_osc3`=0 and `osc3_on`=0 moves the state to SLEEP at the next edge. `sleep_req` wins over a simultaneous `halt_req`.
- R7: In RUN, `sleep_req` while `clk_sel_osc3`=1 or `osc3_on`=1 is refused. The state stays RUN, and `sleep_err` becomes 1 at the next edge. A simultaneous `halt_req` is also dropped.
- R8: `sleep_err` stays 1 until `rst_n` is asserted. A later legal sleep request does not clear it.
- R9: In SLEEP, with `k10_irq`=0, the inputs `irq_pending`, `wdt_timeout`, `halt_req` and `sleep_req` have no effect. The state stays SLEEP with `osc_en`=0.
- R10: In SLEEP, `k10_irq`=1 moves the state to WAKE_WAIT at the next edge. The state is WAKE_WAIT for exactly `STAB_CYCLES` cycles and then RUN. During the wait `osc_en`=1 and `cpu_clk_en`=0.
- R11: In RUN, the inputs `irq_pending`, `wdt_timeout` and `k10_irq` have no effect, and `reset_req` stays 0. In WAKE_WAIT, all request inputs have no effect on the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Pause instruction strobe |
| sleep_req | input | 1 | Deep-stop instruction strobe |
| irq_pending | input | 1 | Any enabled interrupt pending |
| k10_irq | input | 1 | K10 input interrupt request |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| clk_sel_osc3 | input | 1 | 1 when the core clock is the fast oscillator |
| osc3_on | input | 1 | 1 when the fast oscillator is running |
| cpu_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| reset_req | output | 1 | One-cycle restart request after a watchdog expiry |
| cpu_running | output | 1 | Core is executing |
| sleep_err | output | 1 | Sticky flag for a refused deep-stop request |
| state_o | output | 2 | Present state code |

## Verification
All four combinations of clock select and fast-oscillator status are applied to a deep-stop request. This separates the one legal case from each of the two refusal causes and from both causes together. In a pause, the four combinations of interrupt and watchdog expiry separate a normal wake, a restart and a continued pause, and show that the interrupt takes priority. In a deep stop, all sixteen patterns of the non-K10 inputs are applied to show they are ignored. Every pattern is then repeated with K10 high, and each wake's settling window is counted to confirm its exact length.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [1:0] {
    PS_RUN       = 2'b00,
    PS_HALT      = 2'b01,
    PS_SLEEP     = 2'b10,
    PS_WAKE_WAIT = 2'b11
  } pwr_state_e;

  // Deep stop is allowed only on the slow clock with the fast oscillator off.
  function automatic logic sleep_allowed(input logic sel_fast, input logic fast_on);
    return !sel_fast && !fast_on;
  endfunction

  // Counter preload so that the wait state lasts exactly n cycles.
  function automatic int unsigned stab_preload(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/pwr_sleep_guard.sv
module pwr_sleep_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel_osc3,
  input  logic osc3_on,
  input  logic refuse_evt,
  output logic sleep_ok,
  output logic sleep_err
);
  import pwr_state_pkg::*;

  assign sleep_ok = sleep_allowed(clk_sel_osc3, osc3_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sleep_err <= 1'b0;
    else if (refuse_evt) sleep_err <= 1'b1;
  end
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
  parameter int unsigned STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  import pwr_state_pkg::*;

  localparam int unsigned CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] PRELOAD = CW'(stab_preload(STAB_CYCLES));

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= PRELOAD;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      halt_req,
  input  logic                      sleep_req,
  input  logic                      irq_pending,
  input  logic                      k10_irq,
  input  logic                      wdt_timeout,
  input  logic                      sleep_ok,
  input  logic                      stab_zero,
  output pwr_state_pkg::pwr_state_e state,
  output logic                      load_stab,
  output logic                      refuse_evt,
  output logic                      wdt_evt,
  output logic                      reset_req
);
  import pwr_state_pkg::*;

  pwr_state_e nxt;

  always_comb begin
    nxt        = state;
    load_stab  = 1'b0;
    refuse_evt = 1'b0;
    wdt_evt    = 1'b0;
    unique case (state)
      PS_RUN: begin
        if (sleep_req) begin
          if (sleep_ok) nxt = PS_SLEEP;
          else          refuse_evt = 1'b1;
        end else if (halt_req) begin
          nxt = PS_HALT;
        end
      end
      PS_HALT: begin
        if (irq_pending) begin
          nxt = PS_RUN;
        end else if (wdt_timeout) begin
          nxt     = PS_RUN;
          wdt_evt = 1'b1;
        end
      end
      PS_SLEEP: begin
        if (k10_irq) begin
          nxt       = PS_WAKE_WAIT;
          load_stab = 1'b1;
        end
      end
      PS_WAKE_WAIT: begin
        if (stab_zero) nxt = PS_RUN;
      end
      default: nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_RUN;
      reset_req <= 1'b0;
    end else begin
      state     <= nxt;
      reset_req <= wdt_evt;
    end
  end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl #(
  parameter int unsigned STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       sleep_req,
  input  logic       irq_pending,
  input  logic       k10_irq,
  input  logic       wdt_timeout,
  input  logic       clk_sel_osc3,
  input  logic       osc3_on,
  output logic       cpu_clk_en,
  output logic       osc_en,
  output logic       reset_req,
  output logic       cpu_running,
  output logic       sleep_err,
  output logic [1:0] state_o
);
  import pwr_state_pkg::*;

  pwr_state_e state;
  logic sleep_ok, stab_zero, load_stab, refuse_evt, wdt_evt;

  pwr_sleep_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel_osc3 (clk_sel_osc3),
    .osc3_on      (osc3_on),
    .refuse_evt   (refuse_evt),
    .sleep_ok     (sleep_ok),
    .sleep_err    (sleep_err)
  );

  pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_stab),
    .run   (state == PS_WAKE_WAIT),
    .zero  (stab_zero)
  );

  pwr_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .sleep_req   (sleep_req),
    .irq_pending (irq_pending),
    .k10_irq     (k10_irq),
    .wdt_timeout (wdt_timeout),
    .sleep_ok    (sleep_ok),
    .stab_zero   (stab_zero),
    .state       (state),
    .load_stab   (load_stab),
    .refuse_evt  (refuse_evt),
    .wdt_evt     (wdt_evt),
    .reset_req   (reset_req)
  );

  assign state_o     = state;
  assign cpu_clk_en  = (state == PS_RUN);
  assign cpu_running = (state == PS_RUN);
  assign osc_en      = (state != PS_SLEEP);
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       sleep_req,
  input logic       irq_pending,
  input logic       k10_irq,
  input logic       wdt_timeout,
  input logic       clk_sel_osc3,
  input logic       osc3_on,
  input logic       osc_en,
  input logic       reset_req,
  input logic       sleep_err,
  input logic       stab_zero,
  input logic [1:0] state_o
);
  AST_SLEEP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10) |-> !osc_en); // R2
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && halt_req && !sleep_req) |=> (state_o == 2'b01)); // R3
  AST_HALT_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && irq_pending) |=> (state_o == 2'b00 && !reset_req)); // R4
  AST_WDT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && !irq_pending && wdt_timeout) |=> (state_o == 2'b00 && reset_req)); // R5
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R5
  AST_SLEEP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && sleep_req && (clk_sel_osc3 || osc3_on)) |=> (state_o == 2'b00 && sleep_err)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_err |=> sleep_err); // R8
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && !k10_irq) |=> (state_o == 2'b10)); // R9
  AST_K10_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && k10_irq) |=> (state_o == 2'b11)); // R10
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11 && stab_zero) |=> (state_o == 2'b00)); // R10
  AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && !halt_req && !sleep_req) |=> (state_o == 2'b00)); // R11
endmodule

bind pwr_state_ctl pwr_state_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_req     (halt_req),
  .sleep_req    (sleep_req),
  .irq_pending  (irq_pending),
  .k10_irq      (k10_irq),
  .wdt_timeout  (wdt_timeout),
  .clk_sel_osc3 (clk_sel_osc3),
  .osc3_on      (osc3_on),
  .osc_en       (osc_en),
  .reset_req    (reset_req),
  .sleep_err    (sleep_err),
  .stab_zero    (stab_zero),
  .state_o      (state_o)
);

// File: tb/pwr_state_ctl_bench.sv
module pwr_state_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 5;
  localparam logic [1:0] S_RUN = 2'b00, S_HALT = 2'b01, S_SLEEP = 2'b10, S_WAIT = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, sleep_req = 0, irq_pending = 0, k10_irq = 0, wdt_timeout = 0;
  logic clk_sel_osc3 = 0, osc3_on = 0;
  logic cpu_clk_en, osc_en, reset_req, cpu_running, sleep_err;
  logic [1:0] state_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctl #(.STAB_CYCLES(STAB)) u_pwr_state_ctl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .irq_pending(irq_pending), .k10_irq(k10_irq), .wdt_timeout(wdt_timeout),
    .clk_sel_osc3(clk_sel_osc3), .osc3_on(osc3_on), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .reset_req(reset_req), .cpu_running(cpu_running),
    .sleep_err(sleep_err), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Outputs expected from the state code alone.
  task automatic chk_outs(input string req, input logic [1:0] st);
    chk(req, state_o, st);
    chk(req, cpu_clk_en, st == S_RUN);
    chk(req, cpu_running, st == S_RUN);
    chk(req, osc_en, st != S_SLEEP);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_in();
    halt_req = 0; sleep_req = 0; irq_pending = 0; k10_irq = 0; wdt_timeout = 0;
  endtask

  task automatic do_reset();
    clear_in(); clk_sel_osc3 = 0; osc3_on = 0;
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
  endtask

  task automatic enter_halt();
    halt_req = 1; cyc(); halt_req = 0;
  endtask

  task automatic enter_sleep();
    clk_sel_osc3 = 0; osc3_on = 0; sleep_req = 1; cyc(); sleep_req = 0;
  endtask

  // Wake from SLEEP with K10 and measure the wait length.
  task automatic wake_and_count(input string req, input logic [3:0] others);
    int n;
    {irq_pending, wdt_timeout, halt_req, sleep_req} = others;
    k10_irq = 1; cyc(); clear_in();
    chk_outs(req, S_WAIT);
    n = 1;
    while (state_o == S_WAIT && n < 100) begin
      {irq_pending, wdt_timeout, halt_req, sleep_req} = others;
      cyc(); clear_in();
      if (state_o == S_WAIT) n++;
    end
    chk(req, n, STAB);
    chk_outs(req, S_RUN);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(); cyc();
    // R1 state during and after reset
    chk_outs("R1", S_RUN);
    chk("R1", reset_req, 0);
    chk("R1", sleep_err, 0);
    rst_n = 1; cyc();
    chk_outs("R1", S_RUN);

    // R11 in RUN, interrupt/watchdog/K10 sweep has no effect
    for (int v = 0; v < 8; v++) begin
      {irq_pending, wdt_timeout, k10_irq} = 3'(v);
      cyc(); clear_in();
      chk_outs("R11", S_RUN);
      chk("R11", reset_req, 0);
    end

    // R3 / R2 pause entry and outputs
    enter_halt();
    chk_outs("R3", S_HALT);
    chk("R2", state_o, 2'b01);

    // R4 R5 sweep of irq x wdt in HALT
    for (int v = 0; v < 4; v++) begin
      logic i, w;
      {i, w} = 2'(v);
      if (state_o != S_HALT) enter_halt();
      irq_pending = i; wdt_timeout = w; cyc(); clear_in();
      if (i) begin
        chk_outs("R4", S_RUN);
        chk("R4", reset_req, 0);
      end else if (w) begin
        chk_outs("R5", S_RUN);
        chk("R5", reset_req, 1);
        cyc();
        chk("R5", reset_req, 0);
        chk_outs("R5", S_RUN);
      end else begin
        chk_outs("R5", S_HALT);
        chk("R5", reset_req, 0);
        cyc();
        chk_outs("R5", S_HALT);
        irq_pending = 1; cyc(); clear_in();
        chk_outs("R4", S_RUN);
      end
    end

    // R6 legal deep stop, sleep wins over halt
    clk_sel_osc3 = 0; osc3_on = 0; sleep_req = 1; halt_req = 1; cyc(); clear_in();
    chk_outs("R6", S_SLEEP);
    chk("R2", state_o, 2'b10);
    chk("R6", sleep_err, 0);

    // R9 all 16 non-K10 patterns in SLEEP
    for (int v = 0; v < 16; v++) begin
      {irq_pending, wdt_timeout, halt_req, sleep_req} = 4'(v);
      cyc(); clear_in();
      chk_outs("R9", S_SLEEP);
      chk("R9", reset_req, 0);
    end

    // R10 R11 K10 wake with every side pattern during the wait
    for (int v = 0; v < 16; v++) begin
      if (state_o != S_SLEEP) enter_sleep();
      wake_and_count("R10", 4'(v));
    end

    // R7 R8 refusal sweep over clock configuration
    for (int v = 1; v < 4; v++) begin
      {clk_sel_osc3, osc3_on} = 2'(v);
      sleep_req = 1; halt_req = 1; cyc(); clear_in();
      chk_outs("R7", S_RUN);
      chk("R7", sleep_err, 1);
      cyc();
      chk_outs("R7", S_RUN);
    end
    enter_sleep();
    chk_outs("R8", S_SLEEP);
    chk("R8", sleep_err, 1);
    wake_and_count("R8", 4'h0);
    chk("R8", sleep_err, 1);

    // R1 R8 reset clears the sticky flag
    do_reset();
    chk("R8", sleep_err, 0);
    chk_outs("R1", S_RUN);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule